// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the memory address sequence for one DMA work unit. Software loads a start address, an element count and element stride for the inner dimension, and a row count and row stride for the outer dimension. The block then steps once for each data element that the data path presents and that the block accepts. Inside a row it adds the element stride. After the last element of a row it adds the row stride instead, reloads the inner count and decrements the outer count. Chaining rows in this way lets a single work unit move more elements than the 16-bit inner count could reach alone.

The same load also latches the channel configuration. This covers the dimension mode, the transfer direction, a restart request that flushes stale channel FIFO contents, and the interrupt enable. When the final element of the final row is accepted, the block emits a one-cycle completion pulse. If interrupts are enabled, it also raises a sticky interrupt flag, which software clears by writing. The current address and both remaining counts can be read at the ports. These values run ahead of the data actually committed downstream, by however deep the data pipeline is.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `busy`, `done`, `irq_pend`, `fifo_flush` and `to_mem` are 0. `addr` is 0, and both current counts are 0.
- R2: A `load` pulse does four things: it sets `addr` to `ld_start`, sets `cur_xcount` to the inner count, sets `cur_ycount` to the outer count (1 in one-dimensional mode), and raises `busy`. All of these are visible in the cycle after the pulse. `load` takes priority over an element request in the same cycle.
- R3: An element is accepted (`elem_ack` high) in a cycle where `elem_req` is high, `busy` is high and `load` is low. For an accepted element that is not the last of its row, `addr` advances by `ld_xstride` and `cur_xcount` decrements. While `elem_req` is low, `addr` and the counts hold.
- R4: For an accepted element that is the last of a non-final row, `addr` advances by `ld_ystride`, `cur_xcount` reloads the inner count and `cur_ycount` decrements.
- R5: `ld_cfg` bit 0 selects two-dimensional mode. When that bit is 0, `ld_ycount` and `ld_ystride` have no effect and the unit ends after the inner count of elements.
- R6: A count field of 0 means 65536. The count ports are 17 bits wide so that they can show this value.
- R7: Strides are signed two's-complement offsets as wide as the address, so addresses can decrease.
- R8: `done` is high, combinationally, in the cycle in which the final element of the final row is accepted, whether or not interrupts are enabled. From the next cycle `busy` is 0, further requests are not acknowledged, and `addr` holds.
- R9: If `ld_cfg` bit 3 (interrupt enable) was set at load, `irq_pend` is set in the cycle after `done` and stays set until `irq_clr` is high at a clock edge. A completion in the same cycle as a clear keeps the flag set. If bit 3 was 0, `irq_pend` stays 0.
- R10: If `ld_cfg` bit 2 (restart) is set at load, `fifo_flush` is high for exactly the one cycle after the load. Otherwise it stays 0.
- R11: `to_mem` shows `ld_cfg` bit 1 (1 = write to memory) from the cycle after load until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Latch the parameters and start a work unit |
| ld_start | input | AW | Start address |
| ld_xcount | input | CW | Elements per row (0 = 65536) |
| ld_xstride | input | AW | Signed stride between elements of a row |
| ld_ycount | input | CW | Number of rows (0 = 65536) |
| ld_ystride | input | AW | Signed stride applied after the last element of a row |
| ld_cfg | input | 4 | bit0 two-D, bit1 to memory, bit2 restart, bit3 interrupt enable |
| elem_req | input | 1 | Data path offers an element |
| irq_clr | input | 1 | Write strobe that clears the interrupt flag |
| elem_ack | output | 1 | Element accepted this cycle |
| addr | output | AW | Address of the current element |
| cur_xcount | output | CW+1 | Elements left in the current row |
| cur_ycount | output | CW+1 | Rows left, including the current one |
| busy | output | 1 | Work unit in progress |
| to_mem | output | 1 | Latched transfer direction |
| fifo_flush | output | 1 | One-cycle request to discard stale FIFO data |
| done | output | 1 | Final element accepted this cycle |
| irq_pend | output | 1 | Sticky completion interrupt flag |

## Verification
A wrong count or a stride applied in the wrong place shows up on `addr` in the very next cycle after the faulty acceptance. For this reason the bench compares `addr` against an independently computed walk before every accepted element, including at row boundaries and with negative strides. An outer count that is off by one shows up either as a `done` pulse arriving a row early or late, or as `busy` staying high after the expected final element. Both are checked on the exact acceptance cycle. Errors in the interrupt flag and the flush strobe appear one cycle after completion or load, and they are sampled there.

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_start,
  input  logic [CW-1:0] ld_xcount,
  input  logic [AW-1:0] ld_xstride,
  input  logic [CW-1:0] ld_ycount,
  input  logic [AW-1:0] ld_ystride,
  input  logic [3:0]    ld_cfg,
  input  logic          elem_req,
  input  logic          irq_clr,
  output logic          elem_ack,
  output logic [AW-1:0] addr,
  output logic [CW:0]   cur_xcount,
  output logic [CW:0]   cur_ycount,
  output logic          busy,
  output logic          to_mem,
  output logic          fifo_flush,
  output logic          done,
  output logic          irq_pend
);
  localparam int NW = CW + 1;
  localparam logic [NW-1:0] ONE = NW'(1);

  function automatic logic [NW-1:0] widen(input logic [CW-1:0] c);
    return (c == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, c};
  endfunction

  logic [AW-1:0] addr_q, xs_q, ys_q;
  logic [NW-1:0] xrel_q, xcnt_q, ycnt_q;
  logic          busy_q, dir_q, irq_en_q, flush_q, irq_q;

  wire accept  = elem_req & busy_q & ~load;
  wire row_end = (xcnt_q == ONE);
  wire last    = row_end & (ycnt_q == ONE);

  assign elem_ack   = accept;
  assign done       = accept & last;
  assign addr       = addr_q;
  assign cur_xcount = xcnt_q;
  assign cur_ycount = ycnt_q;
  assign busy       = busy_q;
  assign to_mem     = dir_q;
  assign fifo_flush = flush_q;
  assign irq_pend   = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      xs_q     <= '0;
      ys_q     <= '0;
      xrel_q   <= '0;
      xcnt_q   <= '0;
      ycnt_q   <= '0;
      busy_q   <= 1'b0;
      dir_q    <= 1'b0;
      irq_en_q <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      flush_q <= load & ld_cfg[2];
      if (load) begin
        addr_q   <= ld_start;
        xs_q     <= ld_xstride;
        ys_q     <= ld_cfg[0] ? ld_ystride : '0;
        xrel_q   <= widen(ld_xcount);
        xcnt_q   <= widen(ld_xcount);
        ycnt_q   <= ld_cfg[0] ? widen(ld_ycount) : ONE;
        busy_q   <= 1'b1;
        dir_q    <= ld_cfg[1];
        irq_en_q <= ld_cfg[3];
      end else if (accept) begin
        if (last) begin
          busy_q <= 1'b0;
        end else if (row_end) begin
          addr_q <= addr_q + ys_q;
          xcnt_q <= xrel_q;
          ycnt_q <= ycnt_q - ONE;
        end else begin
          addr_q <= addr_q + xs_q;
          xcnt_q <= xcnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  irq_q <= 1'b0;
    else if (done && irq_en_q)   irq_q <= 1'b1;
    else if (irq_clr)            irq_q <= 1'b0;
  end

  // R3
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !row_end) |=> (addr == $past(addr) + $past(xs_q)) && (cur_xcount == $past(cur_xcount) - ONE));

  // R4
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && row_end && !last) |=> (addr == $past(addr) + $past(ys_q)) && (cur_ycount == $past(cur_ycount) - ONE));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!elem_req && !load) |=> $stable(addr) && $stable(cur_xcount) && $stable(cur_ycount));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !busy && !elem_ack);

  // R6
  count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_xcount != '0) && (cur_ycount != '0));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_clr) |=> irq_pend);

  // R10
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> !$past(fifo_flush) || $past(load));
endmodule

// File: tb/dma2d_addr_gen_test.sv
module dma2d_addr_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load = 0;
  logic [31:0] ld_start = 0, ld_xstride = 0, ld_ystride = 0;
  logic [15:0] ld_xcount = 0, ld_ycount = 0;
  logic [3:0]  ld_cfg = 0;
  logic        elem_req = 0, irq_clr = 0;
  logic        elem_ack, busy, to_mem, fifo_flush, done, irq_pend;
  logic [31:0] addr;
  logic [16:0] cur_xcount, cur_ycount;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dma2d_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_start(ld_start),
    .ld_xcount(ld_xcount), .ld_xstride(ld_xstride), .ld_ycount(ld_ycount),
    .ld_ystride(ld_ystride), .ld_cfg(ld_cfg), .elem_req(elem_req),
    .irq_clr(irq_clr), .elem_ack(elem_ack), .addr(addr),
    .cur_xcount(cur_xcount), .cur_ycount(cur_ycount), .busy(busy),
    .to_mem(to_mem), .fifo_flush(fifo_flush), .done(done), .irq_pend(irq_pend));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] s, input logic [15:0] xc, input logic [31:0] xs,
                         input logic [15:0] yc, input logic [31:0] ys, input logic [3:0] cfg);
    ld_start = s; ld_xcount = xc; ld_xstride = xs;
    ld_ycount = yc; ld_ystride = ys; ld_cfg = cfg;
    load = 1;
    @(negedge clk);
    load = 0;
  endtask

  // load, then accept every element, checking each address and the done pulse
  task automatic walk(input string tag, input logic [31:0] s, input logic [15:0] xc,
                      input logic [31:0] xs, input logic [15:0] yc, input logic [31:0] ys,
                      input logic [3:0] cfg, input bit per_elem);
    int ex, ey;
    logic [31:0] a;
    ex = (xc == 0) ? 65536 : int'(xc);
    ey = cfg[0] ? ((yc == 0) ? 65536 : int'(yc)) : 1;
    a = s;
    do_load(s, xc, xs, yc, ys, cfg);
    check({tag, " R2 addr after load"}, addr, s);
    check({tag, " R2/R6 xcount after load"}, 32'(cur_xcount), 32'(ex));
    check({tag, " R2/R5 ycount after load"}, 32'(cur_ycount), 32'(ey));
    check({tag, " R2 busy"}, 32'(busy), 1);
    for (int y = 0; y < ey; y++) begin
      for (int x = 0; x < ex; x++) begin
        bit lst;
        lst = (x == ex - 1) && (y == ey - 1);
        if (per_elem) check({tag, " R3/R4/R7 addr"}, addr, a);
        elem_req = 1;
        #1;
        if (per_elem || lst) check({tag, " R8 done timing"}, 32'(done), 32'(lst));
        @(negedge clk);
        if (x != ex - 1) a = a + xs;
        else if (y != ey - 1) a = a + (cfg[0] ? ys : 32'h0);
      end
      if (per_elem && y == 0 && ey > 1) begin
        elem_req = 0;
        check({tag, " R4 xcount reload"}, 32'(cur_xcount), 32'(ex));
        check({tag, " R4 ycount dec"}, 32'(cur_ycount), 32'(ey - 1));
      end
    end
    check({tag, " R8 busy low after done"}, 32'(busy), 0);
    check({tag, " R8 addr holds at last"}, addr, a);
    #1;
    check({tag, " R8 no ack when idle"}, 32'(elem_ack), 0);
    @(negedge clk);
    check({tag, " R8 addr stable"}, addr, a);
    elem_req = 0;
  endtask

  task automatic t_reset();
    check("R1 busy", 32'(busy), 0);
    check("R1 addr", addr, 0);
    check("R1 counts", 32'(cur_xcount) | 32'(cur_ycount), 0);
    check("R1 irq/flush/dir/done", {28'h0, irq_pend, fifo_flush, to_mem, done}, 0);
  endtask

  task automatic t_two_d();
    do_load(32'h1000, 3, 4, 2, 32'h20, 4'b0001);
    check("R3 hold without req", addr, 32'h1000);
    @(negedge clk);
    check("R3 addr stable while idle req", addr, 32'h1000);
    check("R3 xcount stable", 32'(cur_xcount), 3);
    walk("2D", 32'h1000, 3, 4, 2, 32'h20, 4'b1001, 1);
    check("R9 irq set after done", 32'(irq_pend), 1);
    @(negedge clk);
    check("R9 irq sticky", 32'(irq_pend), 1);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
    check("R9 irq cleared by write", 32'(irq_pend), 0);
  endtask

  task automatic t_one_d();
    walk("1D", 32'h2000, 5, 8, 7, 32'h999, 4'b0000, 1);
    check("R9 no irq when disabled", 32'(irq_pend), 0);
    check("R11 direction read", 32'(to_mem), 0);
  endtask

  task automatic t_negative();
    walk("NEG", 32'h8000, 4, 32'hFFFF_FFFE, 3, 32'hFFFF_FF9C, 4'b0001, 1);
  endtask

  task automatic t_zero_count();
    walk("ZERO", 32'h0, 0, 1, 0, 0, 4'b1000, 0);
    check("R6 final addr after 65536 elems", addr, 32'hFFFF);
    check("R9 irq after long unit", 32'(irq_pend), 1);
  endtask

  task automatic t_cfg();
    ld_cfg = 4'b0110; ld_start = 32'h40; ld_xcount = 2; ld_xstride = 1;
    ld_ycount = 1; ld_ystride = 0;
    load = 1;
    elem_req = 1;
    @(negedge clk);
    load = 0;
    elem_req = 0;
    check("R2 load wins over request", addr, 32'h40);
    check("R10 flush pulse", 32'(fifo_flush), 1);
    check("R11 to_mem set", 32'(to_mem), 1);
    @(negedge clk);
    check("R10 flush single cycle", 32'(fifo_flush), 0);
    check("R11 to_mem held", 32'(to_mem), 1);
    do_load(32'h50, 1, 0, 1, 0, 4'b1000);
    check("R10 no flush without restart", 32'(fifo_flush), 0);
    elem_req = 1;
    irq_clr = 1;
    #1;
    check("R8 done on single element", 32'(done), 1);
    @(negedge clk);
    elem_req = 0;
    irq_clr = 0;
    check("R9 set wins over clear", 32'(irq_pend), 1);
    irq_clr = 1;
    @(negedge clk);
    irq_clr = 0;
  endtask

  initial begin
    #1;
    check("R1 done during reset", 32'(done), 0);
    #20;
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_two_d();
    t_one_d();
    t_negative();
    t_cfg();
    t_zero_count();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule